// File: doc/BRIEF.md
# Time-Slot Stream Demultiplexer

A concentrator sends the outputs of up to eighteen time-to-digital converter channels over a single link. It interleaves them round-robin, one 32-bit word per channel per turn. This block takes the deserialised words, works out from position alone which channel each word belongs to, and produces a write request into that channel's memory partition. A channel with nothing to send fills its turn with an all-zero word. The block discards such words, but they still use up the channel's turn. The link may also carry idle or separator words, which a deserialiser marks as control words. The block drops these and they do not advance the slot position.

Each partition has a write pointer that counts up from zero. When a partition is full, further words for it are not written and a sticky overflow bit is raised for that channel. A word whose upper nibble matches a programmable code is a channel trailer. For each trailer the block gives a one-cycle strobe carrying the channel number and the event number found in the trailer. The trailer word is still written to its partition. All outputs are registered and follow the input word by one clock.

Top module: `tdm_slot_demux`

## Requirements
- R1: After reset is released, `wr_en` and `trl_stb` are low, every bit of `ovf_flags` is 0, the slot position is 0 and every partition pointer is 0.
- R2: Each accepted word (`lnk_valid`=1, `lnk_ctrl`=0) has a slot index. The index counts accepted words and wraps to 0 after index `cfg_active_slots`-1. A non-zero accepted word is written with `wr_ch` equal to its slot index.
- R3: An accepted word equal to 0 gives no write and no trailer strobe, but it still advances the slot index.
- R4: A word with `lnk_valid`=1 and `lnk_ctrl`=1 gives no write and no strobe, and it leaves the slot index unchanged.
- R5: An accepted word with `lnk_sof`=1 takes slot index 0, and the word after it takes index 1 (or 0 when one slot is active).
- R6: The write for a word appears on the clock after it is sampled. `wr_data` equals the word, and `wr_ptr` equals the number of words already written to that partition since reset, starting at 0.
- R7: A non-zero word for a partition already holding `DEPTH` words is not written. It sets bit `ch` of `ovf_flags`, and that bit stays set until reset.
- R8: A non-zero accepted word whose bits [31:28] equal `cfg_trailer_code` pulses `trl_stb` for one clock, one clock later. `trl_ch` gives the slot index and `trl_evt` gives bits [11:0] of the word. This happens even when the word itself overflows.
- R9: A cycle with `lnk_valid`=0 gives no write and no strobe, and it leaves the slot index unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lnk_valid | input | 1 | A word is present on `lnk_data` |
| lnk_ctrl | input | 1 | The present word is an idle/separator word |
| lnk_sof | input | 1 | The present word is the first slot of a frame |
| lnk_data | input | 32 | Link word |
| cfg_active_slots | input | $clog2(NUM_CH+1) | Number of occupied slots, 1..NUM_CH |
| cfg_trailer_code | input | 4 | Upper-nibble code that marks a trailer |
| wr_en | output | 1 | Partition write request |
| wr_ch | output | $clog2(NUM_CH) | Target partition |
| wr_ptr | output | $clog2(DEPTH) | Address within the partition |
| wr_data | output | 32 | Word to store |
| ovf_flags | output | NUM_CH | Sticky per-partition overflow bits |
| trl_stb | output | 1 | Trailer seen (one clock) |
| trl_ch | output | $clog2(NUM_CH) | Channel of the trailer |
| trl_evt | output | 12 | Event number from the trailer |

## Verification
The bench sweeps the active-slot count over 1, 3 and 6 on a six-channel, depth-four build, and runs every sweep with two trailer codes. The stream mixes zero fillers, control words, gaps, mid-stream frame starts and trailers. Zero fillers tell slot advancing apart from writing. Control words and gaps tell them apart from fillers, because those must not advance the slot. A frame start placed off the wrap point exposes a counter that ignores it. With one active slot, channel 0 overflows after four writes. With more active slots, overflow is reached unevenly across channels, which shows that pointers and flags are kept per partition.

// File: rtl/tdm_demux_pkg.sv
// Shared word-field layout for the time-slot demultiplexer.
package tdm_demux_pkg;
    localparam int WORD_W   = 32;
    localparam int CODE_W   = 4;    // trailer marker in the top bits
    localparam int CODE_LSB = WORD_W - CODE_W;
    localparam int EVT_W    = 12;   // event number in the low bits
    typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/tdm_slot_tracker.sv
// Slot position tracker.
// Gives the slot index of the current accepted word and steps the index
// on every accepted word, wrapping after cfg_active-1.
// Assumes cfg_active lies in 1..NUM_CH. A frame start forces index 0.
module tdm_slot_tracker #(
    parameter int NUM_CH = 18,
    localparam int CH_W  = $clog2(NUM_CH),
    localparam int CNT_W = $clog2(NUM_CH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic             sof,
    input  logic [CNT_W-1:0] cfg_active,
    output logic [CH_W-1:0]  cur_slot
);
    logic [CH_W-1:0]  slot_q;
    logic [CNT_W:0]   next_ext;

    // Slot of the present word: frame start overrides the running count.
    always_comb begin
        cur_slot = (adv && sof) ? '0 : slot_q;
        next_ext = (CNT_W + 1)'(cur_slot) + 1'b1;
    end

    // Advance on accepted words only; wrap at the active count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else if (adv) begin
            if (next_ext >= {1'b0, cfg_active}) slot_q <= '0;
            else                                slot_q <= CH_W'(next_ext);
        end
    end
endmodule

// File: rtl/tdm_part_writer.sv
// Partition write control.
// Keeps one fill counter and one sticky overflow bit per channel. It
// registers a write request, or suppresses it when the partition is full.
// Assumes ch < NUM_CH whenever req is high.
module tdm_part_writer
    import tdm_demux_pkg::*;
#(
    parameter int NUM_CH = 18,
    parameter int DEPTH  = 1024,
    localparam int CH_W  = $clog2(NUM_CH),
    localparam int AW    = $clog2(DEPTH),
    localparam int PW    = AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [CH_W-1:0]   ch,
    input  word_t             data,
    output logic              wr_en,
    output logic [CH_W-1:0]   wr_ch,
    output logic [AW-1:0]     wr_ptr,
    output word_t             wr_data,
    output logic [NUM_CH-1:0] ovf
);
    logic [PW-1:0]     fill [NUM_CH];
    logic [NUM_CH-1:0] full;
    logic              sel_full;
    logic [AW-1:0]     sel_ptr;

    // Per-channel fill counters and overflow bits.
    for (genvar g = 0; g < NUM_CH; g++) begin : g_part
        assign full[g] = (fill[g] == PW'(DEPTH));

        // Count accepted writes; flag a write attempted on a full partition.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                fill[g] <= '0;
                ovf[g]  <= 1'b0;
            end else if (req && ch == CH_W'(g)) begin
                if (full[g]) ovf[g]  <= 1'b1;
                else         fill[g] <= fill[g] + 1'b1;
            end
        end
    end

    // Select the addressed partition's state.
    always_comb begin
        sel_full = full[ch];
        sel_ptr  = fill[ch][AW-1:0];
    end

    // Register the outgoing write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en   <= 1'b0;
            wr_ch   <= '0;
            wr_ptr  <= '0;
            wr_data <= '0;
        end else begin
            wr_en   <= req && !sel_full;
            wr_ch   <= ch;
            wr_ptr  <= sel_ptr;
            wr_data <= data;
        end
    end
endmodule

// File: rtl/tdm_trailer_detect.sv
// Trailer recogniser.
// Marks a kept word whose top nibble equals the programmed code, and
// reports its channel and event number for one clock.
module tdm_trailer_detect
    import tdm_demux_pkg::*;
#(
    parameter int NUM_CH = 18,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [CH_W-1:0]   ch,
    input  word_t             data,
    input  logic [CODE_W-1:0] code,
    output logic              stb,
    output logic [CH_W-1:0]   stb_ch,
    output logic [EVT_W-1:0]  stb_evt
);
    // Register the strobe and its channel/event payload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stb     <= 1'b0;
            stb_ch  <= '0;
            stb_evt <= '0;
        end else begin
            stb     <= req && (data[WORD_W-1:CODE_LSB] == code);
            stb_ch  <= ch;
            stb_evt <= data[EVT_W-1:0];
        end
    end
endmodule

// File: rtl/tdm_slot_demux.sv
// Time-slot stream demultiplexer (top).
// Sorts interleaved converter words into per-channel partitions by slot
// position. It drops zero fillers and link control words, and reports
// trailers. Outputs lag the input word by one clock. Assumes that
// cfg_active_slots (1..NUM_CH) and cfg_trailer_code change only while
// the link is quiet.
module tdm_slot_demux
    import tdm_demux_pkg::*;
#(
    parameter int NUM_CH = 18,
    parameter int DEPTH  = 1024,
    localparam int CH_W  = $clog2(NUM_CH),
    localparam int CNT_W = $clog2(NUM_CH + 1),
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lnk_valid,
    input  logic              lnk_ctrl,
    input  logic              lnk_sof,
    input  logic [WORD_W-1:0] lnk_data,
    input  logic [CNT_W-1:0]  cfg_active_slots,
    input  logic [CODE_W-1:0] cfg_trailer_code,
    output logic              wr_en,
    output logic [CH_W-1:0]   wr_ch,
    output logic [AW-1:0]     wr_ptr,
    output logic [WORD_W-1:0] wr_data,
    output logic [NUM_CH-1:0] ovf_flags,
    output logic              trl_stb,
    output logic [CH_W-1:0]   trl_ch,
    output logic [EVT_W-1:0]  trl_evt
);
    logic            accept;
    logic            keep;
    logic [CH_W-1:0] slot;

    // Classify the present word: accepted data, and non-zero kept data.
    always_comb begin
        accept = lnk_valid && !lnk_ctrl;
        keep   = accept && (lnk_data != '0);
    end

    tdm_slot_tracker #(.NUM_CH(NUM_CH)) u_slot (
        .clk        (clk),
        .rst_n      (rst_n),
        .adv        (accept),
        .sof        (lnk_sof),
        .cfg_active (cfg_active_slots),
        .cur_slot   (slot)
    );

    tdm_part_writer #(.NUM_CH(NUM_CH), .DEPTH(DEPTH)) u_wr (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (keep),
        .ch      (slot),
        .data    (lnk_data),
        .wr_en   (wr_en),
        .wr_ch   (wr_ch),
        .wr_ptr  (wr_ptr),
        .wr_data (wr_data),
        .ovf     (ovf_flags)
    );

    tdm_trailer_detect #(.NUM_CH(NUM_CH)) u_trl (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (keep),
        .ch      (slot),
        .data    (lnk_data),
        .code    (cfg_trailer_code),
        .stb     (trl_stb),
        .stb_ch  (trl_ch),
        .stb_evt (trl_evt)
    );
endmodule

// File: rtl/tdm_demux_chk.sv
// Property checker for tdm_slot_demux, attached by bind.
module tdm_demux_chk
    import tdm_demux_pkg::*;
#(
    parameter int NUM_CH = 18,
    localparam int CH_W  = $clog2(NUM_CH),
    localparam int CNT_W = $clog2(NUM_CH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lnk_valid,
    input logic              lnk_ctrl,
    input logic [WORD_W-1:0] lnk_data,
    input logic [CNT_W-1:0]  cfg_active_slots,
    input logic [CODE_W-1:0] cfg_trailer_code,
    input logic              wr_en,
    input logic [CH_W-1:0]   wr_ch,
    input logic [NUM_CH-1:0] ovf_flags,
    input logic              trl_stb
);
    // R3: zero filler words never produce a write or a strobe
    a_r3_zero_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (lnk_valid && !lnk_ctrl && lnk_data == '0) |=> (!wr_en && !trl_stb));

    // R4: control words never produce a write or a strobe
    a_r4_ctrl_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (lnk_valid && lnk_ctrl) |=> (!wr_en && !trl_stb));

    // R9: empty cycles are silent
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !lnk_valid |=> (!wr_en && !trl_stb));

    // R2: written channel lies within the active slot range
    a_r2_ch_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (CNT_W'(wr_ch) < cfg_active_slots));

    // R7: overflow bits never clear while out of reset
    a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flags != '0 |=> ((ovf_flags & $past(ovf_flags)) == $past(ovf_flags)));

    // R7: an overflowed partition receives no more writes
    a_r7_no_write_after_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !ovf_flags[wr_ch]);

    // R8: a strobe follows a word carrying the programmed code
    a_r8_code_match: assert property (@(posedge clk) disable iff (!rst_n)
        trl_stb |-> ($past(lnk_data[WORD_W-1:CODE_LSB]) == $past(cfg_trailer_code)));
endmodule

bind tdm_slot_demux tdm_demux_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .lnk_valid        (lnk_valid),
    .lnk_ctrl         (lnk_ctrl),
    .lnk_data         (lnk_data),
    .cfg_active_slots (cfg_active_slots),
    .cfg_trailer_code (cfg_trailer_code),
    .wr_en            (wr_en),
    .wr_ch            (wr_ch),
    .ovf_flags        (ovf_flags),
    .trl_stb          (trl_stb)
);

// File: tb/tb_tdm_slot_demux.sv
`timescale 1ns/1ps
module tb_tdm_slot_demux;
    localparam int NCH   = 6;
    localparam int DEP   = 4;
    localparam int CH_W  = $clog2(NCH);
    localparam int CNT_W = $clog2(NCH + 1);
    localparam int AW    = $clog2(DEP);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lnk_valid = 1'b0, lnk_ctrl = 1'b0, lnk_sof = 1'b0;
    logic [31:0] lnk_data = '0;
    logic [CNT_W-1:0] cfg_active_slots = CNT_W'(1);
    logic [3:0] cfg_trailer_code = 4'hA;
    logic wr_en, trl_stb;
    logic [CH_W-1:0] wr_ch, trl_ch;
    logic [AW-1:0] wr_ptr;
    logic [31:0] wr_data;
    logic [NCH-1:0] ovf_flags;
    logic [11:0] trl_evt;

    int n_chk = 0, n_bad = 0;
    bit done = 0;
    int m_slot;
    int m_cnt [NCH];
    logic [NCH-1:0] m_ovf;

    always #2.5 clk = ~clk;

    tdm_slot_demux #(.NUM_CH(NCH), .DEPTH(DEP)) dut (
        .clk(clk), .rst_n(rst_n), .lnk_valid(lnk_valid), .lnk_ctrl(lnk_ctrl),
        .lnk_sof(lnk_sof), .lnk_data(lnk_data), .cfg_active_slots(cfg_active_slots),
        .cfg_trailer_code(cfg_trailer_code), .wr_en(wr_en), .wr_ch(wr_ch),
        .wr_ptr(wr_ptr), .wr_data(wr_data), .ovf_flags(ovf_flags),
        .trl_stb(trl_stb), .trl_ch(trl_ch), .trl_evt(trl_evt)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; lnk_valid = 1'b0; lnk_ctrl = 1'b0; lnk_sof = 1'b0; lnk_data = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_slot = 0; m_ovf = '0;
        for (int i = 0; i < NCH; i++) m_cnt[i] = 0;
        #1;
        chk(!wr_en, "R1", "wr_en after reset", wr_en, 0);
        chk(!trl_stb, "R1", "trl_stb after reset", trl_stb, 0);
        chk(ovf_flags == '0, "R1", "ovf after reset", ovf_flags, 0);
    endtask

    // Drive one cycle, update the model and check the registered result.
    task automatic send(input bit v, input bit c, input bit s, input logic [31:0] d);
        bit acc, kp, ew, et;
        int cur, ep;
        string wtag;
        @(negedge clk);
        lnk_valid = v; lnk_ctrl = c; lnk_sof = s; lnk_data = d;
        acc = v && !c;
        cur = (acc && s) ? 0 : m_slot;
        kp = acc && (d != 0);
        ew = 0; ep = 0;
        if (kp) begin
            if (m_cnt[cur] == DEP) m_ovf[cur] = 1'b1;
            else begin ew = 1; ep = m_cnt[cur]; m_cnt[cur]++; end
        end
        et = kp && (d[31:28] == cfg_trailer_code);
        if (acc) m_slot = (cur + 1 >= int'(cfg_active_slots)) ? 0 : cur + 1;
        wtag = !v ? "R9" : (c ? "R4" : (d == 0 ? "R3" : (ew ? "R2" : "R7")));
        @(posedge clk);
        #1;
        chk(wr_en == ew, wtag, "wr_en", wr_en, ew);
        if (ew) begin
            chk(int'(wr_ch) == cur, (acc && s) ? "R5" : "R2", "wr_ch", wr_ch, cur);
            chk(int'(wr_ptr) == ep, "R6", "wr_ptr", wr_ptr, ep);
            chk(wr_data == d, "R6", "wr_data", wr_data, d);
        end
        chk(trl_stb == et, "R8", "trl_stb", trl_stb, et);
        if (et) begin
            chk(int'(trl_ch) == cur, "R8", "trl_ch", trl_ch, cur);
            chk(trl_evt == d[11:0], "R8", "trl_evt", trl_evt, d[11:0]);
        end
        chk(ovf_flags == m_ovf, "R7", "ovf_flags", ovf_flags, m_ovf);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        int acts [3] = '{1, 3, 6};
        logic [3:0] codes [2] = '{4'hA, 4'h3};
        for (int ci = 0; ci < 2; ci++) begin
            for (int ai = 0; ai < 3; ai++) begin
                cfg_active_slots = CNT_W'(acts[ai]);
                cfg_trailer_code = codes[ci];
                do_reset();
                for (int k = 0; k < 60; k++) begin
                    logic [31:0] w;
                    bit v, c, s;
                    w = {4'(1 + (k % 3)), 28'((k * 37 + acts[ai] * 5) | 1)};
                    if (k % 4 == 1) w[31:28] = codes[ci];
                    if (k % 5 == 3) w = '0;
                    v = (k % 9 != 8);
                    c = (k % 13 == 12) || k == 33 || k == 34;
                    s = (k == 0) || (k == 17) || (k == 40);
                    send(v, c, s, w);
                end
            end
        end
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        finish_run();
    end
endmodule